// File: doc/BRIEF.md
# Branch condition and target unit

This unit resolves the conditional, immediate-offset branches of a 32-bit RISC core. The instruction word, the value of the tested register and the PC of that instruction all arrive in one cycle. The unit decodes the word and compares the register value against zero as a signed number. It then adds the sign-extended 16-bit offset to the PC and reports the result. A non-delayed taken branch redirects fetch in the same cycle. A delayed taken branch first lets one more instruction through, the delay slot. A small sequencer holds the target until that instruction has been accepted, and issues the redirect on the following cycle.

Bits are numbered with bit 0 as the most significant bit of the word, so word bit 0 is `instr_i[31]`. The condition code sits in the field that other formats use for the destination register. Bit 6 of the word selects the delayed form.

Top module: `br_unit`

## Requirements
- R1: A word is a branch only when `valid_i` is 1, `instr_i[31:26]` is 101111 and the condition code `instr_i[24:21]` is at most 0101. Any other word never sets `taken_o`, `delay_o` or `illegal_o`, and never redirects.
- R2: The condition codes in `instr_i[24:21]` compare `ra_i` as a signed 32-bit number against zero: 0000 equal, 0001 not equal, 0010 less than, 0011 less or equal, 0100 greater than, 0101 greater or equal. When the sequencer is idle, `taken_o` equals the result of that comparison.
- R3: `target_o` is always `pc_i` plus `instr_i[15:0]` sign-extended to 32 bits, with wrap-around modulo 2^32.
- R4: A not-taken branch, a non-branch word and a delayed taken branch all give `next_pc_o = pc_i + 4`. The first two also give no redirect in that cycle.
- R5: A taken branch with `instr_i[25] = 0` asserts `redirect_o` in the same cycle, with `redirect_addr_o = target_o` and `next_pc_o = target_o`.
- R6: A taken branch with `instr_i[25] = 1` sets `delay_o` and does not redirect in that cycle. `slot_o` is then 1 from the next cycle until a valid instruction is accepted.
- R7: In the cycle after the delay-slot instruction is accepted, `redirect_o` is 1 for exactly one cycle, carrying the saved target. Cycles in which `valid_i` is 0 leave the slot open.
- R8: A branch presented in a delay slot raises `illegal_o` and sets neither `taken_o` nor `delay_o`. It leaves the saved target unchanged.
- R9: In the redirect cycle of a delayed branch the presented instruction is ignored: `taken_o`, `delay_o` and `illegal_o` stay 0.
- R10: During and right after reset, `redirect_o`, `slot_o` and `illegal_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction accepted this cycle |
| instr_i | input | 32 | Instruction word |
| ra_i | input | 32 | Value of the tested register |
| pc_i | input | 32 | Address of the instruction |
| taken_o | output | 1 | Branch condition met and branch legal |
| target_o | output | 32 | PC plus sign-extended offset |
| next_pc_o | output | 32 | Next sequential or redirected address |
| delay_o | output | 1 | Taken delayed branch: a delay slot follows |
| slot_o | output | 1 | Sequencer is waiting for the delay-slot instruction |
| illegal_o | output | 1 | Branch found in a delay slot |
| redirect_o | output | 1 | Fetch must go to redirect_addr_o |
| redirect_addr_o | output | 32 | Redirect address |

## Verification
Random words mix the branch opcode with other opcodes, all eight low code values, both delay forms and register values drawn near the sign boundary. This separates signed from unsigned comparison and valid codes from invalid ones. Directed runs show the delay slot with idle cycles inside it, a branch in the slot, and a branch offered during the redirect cycle, which separates waiting, illegal detection and input masking. Offsets 0x8000 and 0x7fff, together with PCs near the top of the address space, show correct sign extension and wrap-around.

// File: rtl/br_unit_pkg.sv
package br_unit_pkg;
  typedef enum logic [3:0] {
    CC_EQ = 4'd0,
    CC_NE = 4'd1,
    CC_LT = 4'd2,
    CC_LE = 4'd3,
    CC_GT = 4'd4,
    CC_GE = 4'd5
  } cc_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SLOT  = 2'd1,
    SQ_REDIR = 2'd2
  } sq_e;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_unit_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int OPC_W   = 6,
  parameter int CC_W    = 5,
  parameter int IMM_W   = 16,
  parameter logic [OPC_W-1:0] OPC_BR = 6'b101111
) (
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               is_br_o,
  output logic               delayed_o,
  output cc_e                cc_o,
  output logic [IMM_W-1:0]   imm_o
);
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int CC_LSB  = OPC_LSB - CC_W;

  logic [CC_W-2:0] code;
  logic            opc_hit;
  logic            code_ok;

  assign opc_hit   = instr_i[INSTR_W-1 -: OPC_W] == OPC_BR;
  assign code      = instr_i[CC_LSB +: CC_W-1];
  assign code_ok   = code <= CC_W'(CC_GE);
  assign delayed_o = instr_i[CC_LSB + CC_W - 1];
  assign cc_o      = cc_e'(code);
  assign imm_o     = instr_i[IMM_W-1:0];
  assign is_br_o   = valid_i & opc_hit & code_ok;
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_unit_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] ra_i,
  input  cc_e             cc_i,
  output logic            hit_o
);
  logic neg;
  logic zero;

  assign neg  = ra_i[XLEN-1];
  assign zero = ra_i == '0;

  always_comb begin
    unique case (cc_i)
      CC_EQ:   hit_o = zero;
      CC_NE:   hit_o = ~zero;
      CC_LT:   hit_o = neg;
      CC_LE:   hit_o = neg | zero;
      CC_GT:   hit_o = ~neg & ~zero;
      CC_GE:   hit_o = ~neg;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int XLEN        = 32,
  parameter int IMM_W       = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  target_o,
  output logic [XLEN-1:0]  seq_o
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] offs;

  assign offs     = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign target_o = pc_i + offs;
  assign seq_o    = pc_i + XLEN'(INSTR_BYTES);
endmodule

// File: rtl/br_seq.sv
module br_seq
  import br_unit_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            arm_i,
  input  logic [XLEN-1:0] tgt_i,
  output sq_e             state_o,
  output logic [XLEN-1:0] tgt_o
);
  sq_e             state_q, state_d;
  logic [XLEN-1:0] tgt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:  if (arm_i) state_d = SQ_SLOT;
      SQ_SLOT:  if (valid_i) state_d = SQ_REDIR;
      SQ_REDIR: state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SQ_IDLE && arm_i) tgt_q <= tgt_i;
    end
  end

  assign state_o = state_q;
  assign tgt_o   = tgt_q;

  AST_SLOT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_SLOT && valid_i) |=> state_q == SQ_REDIR); // R7
  AST_SLOT_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_SLOT && !valid_i) |=> state_q == SQ_SLOT); // R7
  AST_REDIR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_REDIR) |=> state_q == SQ_IDLE); // R7
  AST_TGT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_SLOT) |=> $stable(tgt_q)); // R8
endmodule

// File: rtl/br_unit.sv
module br_unit
  import br_unit_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int INSTR_W     = 32,
  parameter int IMM_W       = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [XLEN-1:0]    ra_i,
  input  logic [XLEN-1:0]    pc_i,
  output logic               taken_o,
  output logic [XLEN-1:0]    target_o,
  output logic [XLEN-1:0]    next_pc_o,
  output logic               delay_o,
  output logic               slot_o,
  output logic               illegal_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_addr_o
);
  logic             is_br, delayed, hit;
  cc_e              cc;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  tgt, seq_pc, tgt_q;
  sq_e              state;
  logic             idle, in_redir, taken_now;

  br_decode #(.INSTR_W(INSTR_W), .IMM_W(IMM_W)) u_dec (
    .valid_i(valid_i), .instr_i(instr_i), .is_br_o(is_br),
    .delayed_o(delayed), .cc_o(cc), .imm_o(imm)
  );

  br_cond_eval #(.XLEN(XLEN)) u_cond (
    .ra_i(ra_i), .cc_i(cc), .hit_o(hit)
  );

  br_target #(.XLEN(XLEN), .IMM_W(IMM_W), .INSTR_BYTES(INSTR_BYTES)) u_tgt (
    .pc_i(pc_i), .imm_i(imm), .target_o(tgt), .seq_o(seq_pc)
  );

  br_seq #(.XLEN(XLEN)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .arm_i(delay_o),
    .tgt_i(tgt), .state_o(state), .tgt_o(tgt_q)
  );

  assign idle      = state == SQ_IDLE;
  assign in_redir  = state == SQ_REDIR;
  assign slot_o    = state == SQ_SLOT;
  assign taken_o   = is_br & idle & hit;
  assign delay_o   = taken_o & delayed;
  assign taken_now = taken_o & ~delayed;
  assign illegal_o = is_br & slot_o;

  assign target_o        = tgt;
  assign next_pc_o       = taken_now ? tgt : seq_pc;
  assign redirect_o      = in_redir | taken_now;
  assign redirect_addr_o = in_redir ? tgt_q : tgt;

  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!taken_o && !delay_o && !redirect_o)); // R8
  AST_ARM_OPENS_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_o |=> slot_o); // R6
  AST_REDIR_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(slot_o && valid_i) |-> (redirect_o && !taken_o && !illegal_o)); // R9
endmodule

// File: tb/br_unit_tb.sv
module br_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        valid = 0;
  logic [31:0] instr = 0, ra = 0, pc = 0;
  logic        taken, delay, slot, illegal, redirect;
  logic [31:0] target, next_pc, raddr;

  int n_chk = 0, n_fail = 0;
  int ms = 0;
  logic [31:0] mt = 0;

  always #5 clk = ~clk;

  br_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr), .ra_i(ra),
    .pc_i(pc), .taken_o(taken), .target_o(target), .next_pc_o(next_pc),
    .delay_o(delay), .slot_o(slot), .illegal_o(illegal),
    .redirect_o(redirect), .redirect_addr_o(raddr)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic opc_ok, input logic dl,
                                     input logic [3:0] code, input logic [15:0] imm);
    return {opc_ok ? 6'b101111 : 6'b100111, dl, code, 5'd3, imm};
  endfunction

  function automatic logic hit_of(input logic [3:0] c, input logic [31:0] r);
    case (c)
      4'd0: return $signed(r) == 0;
      4'd1: return $signed(r) != 0;
      4'd2: return $signed(r) < 0;
      4'd3: return $signed(r) <= 0;
      4'd4: return $signed(r) > 0;
      4'd5: return $signed(r) >= 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] r,
                      input logic [31:0] p);
    logic isb, dl, e_tk, e_dl, e_il, e_rd, now;
    logic [31:0] tg, e_ra, e_nx;
    string t;
    @(negedge clk);
    valid = v; instr = w; ra = r; pc = p;
    #1;
    dl   = w[25];
    isb  = v && (w[31:26] == 6'b101111) && (w[24:21] <= 4'd5);
    tg   = p + {{16{w[15]}}, w[15:0]};
    e_tk = isb && ms == 0 && hit_of(w[24:21], r);
    now  = e_tk && !dl;
    e_dl = e_tk && dl;
    e_il = isb && ms == 1;
    e_rd = (ms == 2) || now;
    e_ra = (ms == 2) ? mt : tg;
    e_nx = now ? tg : p + 32'd4;
    t = (ms == 2) ? "R9" : (ms == 1 && isb) ? "R8" : !isb ? "R1" : "R2";
    check(t, "taken", {31'b0, taken}, {31'b0, e_tk});
    check(t, "delay", {31'b0, delay}, {31'b0, e_dl});
    check(ms == 1 ? "R8" : t, "illegal", {31'b0, illegal}, {31'b0, e_il});
    check("R3", "target", target, tg);
    check(now ? "R5" : "R4", "next_pc", next_pc, e_nx);
    check(ms == 2 ? "R7" : "R5", "redirect", {31'b0, redirect}, {31'b0, e_rd});
    if (e_rd) check(ms == 2 ? "R7" : "R5", "redirect_addr", raddr, e_ra);
    check("R6", "slot", {31'b0, slot}, {31'b0, ms == 1});
    @(posedge clk);
    case (ms)
      0: if (e_dl) begin ms = 1; mt = tg; end
      1: if (v) ms = 2;
      default: ms = 0;
    endcase
  endtask

  function automatic logic [31:0] pick_ra(input int k);
    case (k % 7)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hffff_ffff;
      3: return 32'h8000_0000;
      4: return 32'h7fff_ffff;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    check("R10", "redirect in reset", {31'b0, redirect}, 32'd0);
    check("R10", "slot in reset", {31'b0, slot}, 32'd0);
    check("R10", "illegal in reset", {31'b0, illegal}, 32'd0);
    @(negedge clk); rst_n = 1;
    // R2: signed boundary, non-delayed gt on most negative
    step(1, mk(1, 0, 4'd4, 16'h0010), 32'h8000_0000, 32'h100);
    step(1, mk(1, 0, 4'd3, 16'h0010), 32'h8000_0000, 32'h100);
    // R3: negative offset and wrap-around
    step(1, mk(1, 0, 4'd0, 16'h8000), 32'h0, 32'h0000_4000);
    step(1, mk(1, 0, 4'd0, 16'h7fff), 32'h0, 32'hffff_fff0);
    // R6 R7 R8 R9: delayed taken, gaps in slot, branch in slot, branch in redirect cycle
    step(1, mk(1, 1, 4'd3, 16'h0040), 32'h0, 32'h200);
    step(0, 32'h0, 32'h0, 32'h204);
    step(0, 32'h0, 32'h0, 32'h204);
    step(1, mk(1, 0, 4'd0, 16'h0400), 32'h0, 32'h204);
    step(1, mk(1, 0, 4'd0, 16'h0400), 32'h0, 32'h208);
    step(1, mk(1, 0, 4'd5, 16'h0008), 32'h5, 32'h240);
    // R1: invalid codes and foreign opcode
    step(1, mk(1, 0, 4'd6, 16'h0008), 32'h0, 32'h300);
    step(1, mk(0, 0, 4'd0, 16'h0008), 32'h0, 32'h304);
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c;
      c = ($urandom % 5 == 0) ? 4'($urandom) : 4'($urandom % 8);
      step(($urandom % 8) != 0,
           mk(($urandom % 6) != 0, 1'($urandom), c, 16'($urandom)),
           pick_ra(int'($urandom % 100)), {$urandom} & 32'hffff_fffc);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule